// File: doc/BRIEF.md
# Bank-and-Page Shaped Memory Request Generator

This block produces a stream of memory requests whose addresses stress DRAM timing along two axes: how many back-to-back requests land in one open page, and how many banks are kept busy. Requests come in runs. Each run picks a fresh random row and a random bank from a chosen subset of banks. It then walks consecutive columns, one request size per step, until a stride of configured length has been covered inside that page. Address bits are laid out under one of two row/column/bank arrangements. A single channel and a single rank are assumed, so neither takes any address bits.

A level-sensitive `run` input starts and stops generation. The configuration pins must stay constant while `run` is high. On the rising edge of `run`, the configuration is checked. A bad setting parks the block in an error state and no request is issued. The request leaves on a valid/ready port. While `req_valid` is high and `req_ready` is low, the request is held unchanged. A request is transferred in any cycle where both are high. Only after that transfer does a random idle gap start counting. A 32-bit LFSR, loaded from `cfg_seed` at each start, supplies all randomness, so a given seed always produces the same stream.

Top module: `dram_pattern_gen`

## Requirements
- R1: After reset, `req_valid` and `cfg_err` are low.
- R2: When `run` rises with a bad configuration, `cfg_err` goes high and stays high until `run` falls, and no request is issued. A configuration is bad when any of these hold:
  - the request size, page size, bank total or range (`cfg_limit - cfg_base`) is not a power of two;
  - the stride is zero, is not a multiple of the request size, or exceeds the page;
  - the banks used is zero or above the total;
  - the minimum gap exceeds the maximum;
  - the read percentage is above 100;
  - the base is not aligned to the request size;
  - the range is smaller than page size times bank total.
- R3: With a good configuration, `run` sampled high while idle gives `req_valid` low after the first clock edge and high after the second.
- R4: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_write` and `req_size` stay unchanged.
- R5: Every request address lies in [`cfg_base`, `cfg_limit`) and is a multiple of the request size. `req_size` equals `cfg_req_bytes`.
- R6: Requests form runs of stride/request-size requests, counted from the first request after start. Within a run, the row and bank are constant and the column index rises by one per request. Each run fits inside one page.
- R7: The bank index of every request is below `cfg_banks_used`.
- R8: With offset = address - base, r = log2(request size), p = log2(page size) and b = log2(bank total), the row sits at bit p+b and up in both mappings. With `cfg_map_sel`=1, the bank is at bits [p+b-1:p] and the column index at bits [p-1:r]. With `cfg_map_sel`=0, the column index is at bits [p+b-1:r+b] and the bank at bits [r+b-1:r].
- R9: `req_write`=0 marks a read and `req_write`=1 a write. A read percentage of 0 gives only writes, and 100 gives only reads.
- R10: After a transfer, `req_valid` is low for exactly gap+1 cycles before the next request, where gap is drawn in [`cfg_gap_min`, `cfg_gap_max`].
- R11: The LFSR is loaded from `cfg_seed` at each start, with a zero seed replaced by 1. Equal seeds and configurations give equal request streams.
- R12: When `run` falls, a pending request stays valid until it is transferred, and no further request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Level enable; rising edge loads seed and checks configuration |
| cfg_base | input | AW | First byte of the address window |
| cfg_limit | input | AW | One past the last byte of the window |
| cfg_req_bytes | input | SW | Request size in bytes |
| cfg_stride_bytes | input | SW | Bytes covered by one same-page run |
| cfg_page_bytes | input | SW | Page size in bytes |
| cfg_banks_total | input | BW | Banks in the device |
| cfg_banks_used | input | BW | Banks that may be targeted (indices 0..n-1) |
| cfg_map_sel | input | 1 | Address layout select (see R8) |
| cfg_read_pct | input | PW | Read probability in percent |
| cfg_gap_min | input | GW | Smallest idle gap in cycles |
| cfg_gap_max | input | GW | Largest idle gap in cycles |
| cfg_seed | input | 32 | LFSR start value |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Consumer accepts request |
| req_addr | output | AW | Request byte address |
| req_write | output | 1 | 1 = write, 0 = read |
| req_size | output | SW | Request size in bytes |
| cfg_err | output | 1 | Configuration rejected |

## Verification
Two events can land in the same cycle: the fall of `run` and a request that is stalled by back-pressure. The bench lowers `run` while `req_ready` is held low with a request pending. It then checks that the request keeps its address for several cycles, is transferred once, and is followed by silence. The second coincidence is a transfer on the last request of a run: at that moment a new row and bank are drawn. The bench crosses run boundaries under both mappings, with stalls on alternate requests. It judges every request against the decoded row, bank and column of the one before it.

// File: rtl/dpg_pkg.sv
`timescale 1ns/1ps
package dpg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ISSUE,
    ST_GAP,
    ST_ERR
  } dpg_state_e;

  // index of the highest set bit (exact log2 for powers of two)
  function automatic logic [6:0] lg2(input logic [63:0] v);
    logic [6:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) r = 7'(i);
    end
    return r;
  endfunction

  function automatic logic is_pow2(input logic [63:0] v);
    return (v != 64'd0) && ((v & (v - 64'd1)) == 64'd0);
  endfunction

endpackage

// File: rtl/dpg_lfsr.sv
`timescale 1ns/1ps
module dpg_lfsr #(
  parameter int W = 32,
  parameter logic [W-1:0] TAPS = W'(32'h80200003)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state
);

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= W'(1);
    end else if (load) begin
      q <= (seed == '0) ? W'(1) : seed;
    end else if (step) begin
      q <= (q >> 1) ^ (q[0] ? TAPS : '0);
    end
  end

  assign state = q;

  // R11
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0);

endmodule

// File: rtl/dpg_cfg_check.sv
`timescale 1ns/1ps
module dpg_cfg_check import dpg_pkg::*; #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int BW = 8,
  parameter int GW = 16,
  parameter int PW = 7
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  input  logic [SW-1:0] req_b,
  input  logic [SW-1:0] stride_b,
  input  logic [SW-1:0] page_b,
  input  logic [BW-1:0] nb,
  input  logic [BW-1:0] used,
  input  logic [GW-1:0] gmin,
  input  logic [GW-1:0] gmax,
  input  logic [PW-1:0] pct,
  output logic          ok,
  output logic [6:0]    req_lg,
  output logic [6:0]    page_lg,
  output logic [6:0]    bank_lg,
  output logic [AW-1:0] range_mask,
  output logic [SW-1:0] beats,
  output logic [SW-1:0] cols
);

  logic [AW-1:0] span;
  logic [6:0]    span_lg;
  logic          sizes_ok, stride_ok, banks_ok, misc_ok;

  always_comb begin
    span       = limit - base;
    req_lg     = lg2(64'(req_b));
    page_lg    = lg2(64'(page_b));
    bank_lg    = lg2(64'(nb));
    span_lg    = lg2(64'(span));
    range_mask = span - AW'(1);
    beats      = stride_b >> req_lg;
    cols       = page_b >> req_lg;

    sizes_ok  = (limit > base) && is_pow2(64'(span)) && is_pow2(64'(req_b))
             && is_pow2(64'(page_b)) && is_pow2(64'(nb)) && (req_b <= page_b);
    stride_ok = (stride_b != '0) && ((stride_b & (req_b - SW'(1))) == '0)
             && (stride_b <= page_b);
    banks_ok  = (used != '0) && (used <= nb);
    misc_ok   = (gmin <= gmax) && (32'(pct) <= 32'd100)
             && ((base & AW'(req_b - SW'(1))) == '0)
             && (span_lg >= page_lg + bank_lg);
    ok = sizes_ok && stride_ok && banks_ok && misc_ok;
  end

endmodule

// File: rtl/dpg_addr_build.sv
`timescale 1ns/1ps
module dpg_addr_build #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int BW = 8
) (
  input  logic [AW-1:0] row,
  input  logic [BW-1:0] bank,
  input  logic [SW-1:0] col,
  input  logic          map_sel,
  input  logic [6:0]    req_lg,
  input  logic [6:0]    page_lg,
  input  logic [6:0]    bank_lg,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] range_mask,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] hi, mid, lo;

  always_comb begin
    hi = row << (page_lg + bank_lg);
    if (map_sel) begin
      // row | bank | column
      mid = AW'(bank) << page_lg;
      lo  = AW'(col) << req_lg;
    end else begin
      // row | column | bank
      mid = AW'(col) << (req_lg + bank_lg);
      lo  = AW'(bank) << req_lg;
    end
    addr = base + ((hi | mid | lo) & range_mask);
  end

endmodule

// File: rtl/dram_pattern_gen.sv
`timescale 1ns/1ps
module dram_pattern_gen import dpg_pkg::*; #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int BW = 8,
  parameter int GW = 16,
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_limit,
  input  logic [SW-1:0] cfg_req_bytes,
  input  logic [SW-1:0] cfg_stride_bytes,
  input  logic [SW-1:0] cfg_page_bytes,
  input  logic [BW-1:0] cfg_banks_total,
  input  logic [BW-1:0] cfg_banks_used,
  input  logic          cfg_map_sel,
  input  logic [PW-1:0] cfg_read_pct,
  input  logic [GW-1:0] cfg_gap_min,
  input  logic [GW-1:0] cfg_gap_max,
  input  logic [31:0]   cfg_seed,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic          req_write,
  output logic [SW-1:0] req_size,
  output logic          cfg_err
);

  localparam int LW = 32;

  dpg_state_e    st_q;
  logic [AW-1:0] row_q;
  logic [BW-1:0] bank_q;
  logic [SW-1:0] col_q, left_q;
  logic [GW-1:0] gap_q;
  logic [AW-1:0] addr_q;
  logic          write_q;
  logic [SW-1:0] size_q;

  logic          cfg_ok;
  logic [6:0]    req_lg, page_lg, bank_lg;
  logic [AW-1:0] range_mask;
  logic [SW-1:0] beats, cols;
  logic [LW-1:0] s;
  logic          seed_load, lfsr_step;

  dpg_cfg_check #(.AW(AW), .SW(SW), .BW(BW), .GW(GW), .PW(PW)) u_chk (
    .base(cfg_base), .limit(cfg_limit), .req_b(cfg_req_bytes),
    .stride_b(cfg_stride_bytes), .page_b(cfg_page_bytes),
    .nb(cfg_banks_total), .used(cfg_banks_used),
    .gmin(cfg_gap_min), .gmax(cfg_gap_max), .pct(cfg_read_pct),
    .ok(cfg_ok), .req_lg(req_lg), .page_lg(page_lg), .bank_lg(bank_lg),
    .range_mask(range_mask), .beats(beats), .cols(cols)
  );

  assign seed_load = (st_q == ST_IDLE) && run;
  assign lfsr_step = (st_q != ST_IDLE);

  dpg_lfsr #(.W(LW)) u_rng (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(cfg_seed),
    .step(lfsr_step), .state(s)
  );

  // random draws, all scaled by multiply-and-shift
  logic [15:0]      r_hi, r_mid;
  logic [7:0]       r_lo;
  logic [8+BW-1:0]  bank_prod;
  logic [SW:0]      col_span;
  logic [16+SW:0]   col_prod;
  logic [22:0]      rd_prod;
  logic [GW:0]      gap_span;
  logic [16+GW:0]   gap_prod;
  logic [BW-1:0]    new_bank;
  logic [SW-1:0]    new_col;
  logic [GW-1:0]    gap_draw;
  logic             rd_draw;

  always_comb begin
    r_hi      = s[31:16];
    r_mid     = s[23:8];
    r_lo      = s[15:8];
    bank_prod = (8+BW)'(r_lo) * (8+BW)'(cfg_banks_used);
    new_bank  = bank_prod[8+BW-1:8];
    col_span  = {1'b0, cols} - {1'b0, beats} + (SW+1)'(1);
    col_prod  = (17+SW)'(r_hi) * (17+SW)'(col_span);
    new_col   = col_prod[16+SW-1:16];
    rd_prod   = 23'(r_mid) * 23'd100;
    rd_draw   = 32'(rd_prod[22:16]) < 32'(cfg_read_pct);
    gap_span  = {1'b0, cfg_gap_max} - {1'b0, cfg_gap_min} + (GW+1)'(1);
    gap_prod  = (17+GW)'(r_hi) * (17+GW)'(gap_span);
    gap_draw  = cfg_gap_min + gap_prod[16+GW-1:16];
  end

  // next request fields
  logic          do_load, new_run;
  logic [AW-1:0] cur_row, cur_addr;
  logic [BW-1:0] cur_bank;
  logic [SW-1:0] cur_col, cur_left;

  always_comb begin
    do_load  = (st_q == ST_START) || ((st_q == ST_GAP) && run && (gap_q == '0));
    new_run  = (left_q == '0);
    cur_row  = new_run ? AW'(s) : row_q;
    cur_bank = new_run ? new_bank : bank_q;
    cur_col  = new_run ? new_col : col_q + SW'(1);
    cur_left = new_run ? beats - SW'(1) : left_q - SW'(1);
  end

  dpg_addr_build #(.AW(AW), .SW(SW), .BW(BW)) u_addr (
    .row(cur_row), .bank(cur_bank), .col(cur_col), .map_sel(cfg_map_sel),
    .req_lg(req_lg), .page_lg(page_lg), .bank_lg(bank_lg),
    .base(cfg_base), .range_mask(range_mask), .addr(cur_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      row_q   <= '0;
      bank_q  <= '0;
      col_q   <= '0;
      left_q  <= '0;
      gap_q   <= '0;
      addr_q  <= '0;
      write_q <= 1'b0;
      size_q  <= '0;
    end else begin
      if (do_load) begin
        row_q   <= cur_row;
        bank_q  <= cur_bank;
        col_q   <= cur_col;
        left_q  <= cur_left;
        addr_q  <= cur_addr;
        write_q <= !rd_draw;
        size_q  <= cfg_req_bytes;
      end
      unique case (st_q)
        ST_IDLE: begin
          left_q <= '0;
          if (run) st_q <= cfg_ok ? ST_START : ST_ERR;
        end
        ST_START: st_q <= ST_ISSUE;
        ST_ISSUE: begin
          if (req_ready) begin
            gap_q <= gap_draw;
            st_q  <= run ? ST_GAP : ST_IDLE;
          end
        end
        ST_GAP: begin
          if (!run)              st_q  <= ST_IDLE;
          else if (gap_q == '0)  st_q  <= ST_ISSUE;
          else                   gap_q <= gap_q - GW'(1);
        end
        ST_ERR: if (!run) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (st_q == ST_ISSUE);
  assign cfg_err   = (st_q == ST_ERR);
  assign req_addr  = addr_q;
  assign req_write = write_q;
  assign req_size  = size_q;

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)
      && $stable(req_write) && $stable(req_size));

  // R10
  gap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);

  // R2
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && run |=> cfg_err);

  // R7
  bank_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> bank_q < cfg_banks_used);

  // R5
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req_addr & AW'(req_size - SW'(1))) == '0)
      && (req_addr >= cfg_base) && (req_addr < cfg_limit));

endmodule

// File: tb/sim_dram_pattern_gen.sv
`timescale 1ns/1ps
module sim_dram_pattern_gen;

  typedef struct packed {
    logic        map;
    logic [31:0] base;
    logic [31:0] limit;
    logic [15:0] req;
    logic [15:0] stride;
    logic [15:0] page;
    logic [7:0]  nb;
    logic [7:0]  used;
    logic [6:0]  pct;
    logic [15:0] gmin;
    logic [15:0] gmax;
    logic [31:0] seed;
    logic        err;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0, 32'h0800_0000, 16'd32, 16'd96,   16'd1024, 8'd8,  8'd6, 7'd50,  16'd3, 16'd9, 32'h0000_1234, 1'b0},
    '{1'b0, 32'h0, 32'h0800_0000, 16'd32, 16'd96,   16'd1024, 8'd8,  8'd6, 7'd0,   16'd2, 16'd6, 32'h0000_BEEF, 1'b0},
    '{1'b1, 32'h0, 32'h0800_0000, 16'd64, 16'd64,   16'd2048, 8'd4,  8'd4, 7'd100, 16'd0, 16'd0, 32'h00C0_FFEE, 1'b0},
    '{1'b0, 32'h0010_0000, 32'h0020_0000, 16'd16, 16'd256, 16'd256, 8'd16, 8'd1, 7'd30, 16'd2, 16'd5, 32'h5A5A_0001, 1'b0},
    '{1'b1, 32'h0, 32'h0800_0000, 16'd32, 16'd2048, 16'd1024, 8'd8,  8'd6, 7'd50,  16'd3, 16'd9, 32'h1, 1'b1},
    '{1'b1, 32'h0, 32'h0800_0000, 16'd32, 16'd96,   16'd1024, 8'd8,  8'd9, 7'd50,  16'd3, 16'd9, 32'h1, 1'b1},
    '{1'b1, 32'h0, 32'h0800_0000, 16'd48, 16'd96,   16'd1024, 8'd8,  8'd6, 7'd50,  16'd3, 16'd9, 32'h1, 1'b1},
    '{1'b0, 32'h0, 32'h0800_0000, 16'd32, 16'd80,   16'd1024, 8'd8,  8'd6, 7'd50,  16'd3, 16'd9, 32'h1, 1'b1},
    '{1'b0, 32'h0, 32'h0800_0000, 16'd32, 16'd96,   16'd1000, 8'd8,  8'd6, 7'd50,  16'd3, 16'd9, 32'h1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [31:0] cfg_base, cfg_limit, cfg_seed;
  logic [15:0] cfg_req_bytes, cfg_stride_bytes, cfg_page_bytes;
  logic [7:0]  cfg_banks_total, cfg_banks_used;
  logic        cfg_map_sel;
  logic [6:0]  cfg_read_pct;
  logic [15:0] cfg_gap_min, cfg_gap_max;
  logic        req_valid, req_ready, req_write, cfg_err;
  logic [31:0] req_addr;
  logic [15:0] req_size;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dram_pattern_gen u0 (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_req_bytes(cfg_req_bytes), .cfg_stride_bytes(cfg_stride_bytes),
    .cfg_page_bytes(cfg_page_bytes), .cfg_banks_total(cfg_banks_total),
    .cfg_banks_used(cfg_banks_used), .cfg_map_sel(cfg_map_sel),
    .cfg_read_pct(cfg_read_pct), .cfg_gap_min(cfg_gap_min),
    .cfg_gap_max(cfg_gap_max), .cfg_seed(cfg_seed),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int lgb(input longint v);
    int r = 0;
    for (int i = 0; i < 63; i++) if (v[i]) r = i;
    return r;
  endfunction

  // decode per R8
  task automatic decode(input vec_t v, input logic [31:0] a,
                        output longint row, output longint bank, output longint col);
    longint off = longint'(a) - longint'(v.base);
    int rl = lgb(longint'(v.req));
    int pl = lgb(longint'(v.page));
    int bl = lgb(longint'(v.nb));
    longint ncol = longint'(v.page) >> rl;
    if (v.map) begin
      bank = (off >> pl) & (longint'(v.nb) - 1);
      col  = (off >> rl) & (ncol - 1);
    end else begin
      bank = (off >> rl) & (longint'(v.nb) - 1);
      col  = (off >> (rl + bl)) & (ncol - 1);
    end
    row = off >> (pl + bl);
  endtask

  task automatic apply(input vec_t v);
    cfg_map_sel = v.map;       cfg_base = v.base;        cfg_limit = v.limit;
    cfg_req_bytes = v.req;     cfg_stride_bytes = v.stride; cfg_page_bytes = v.page;
    cfg_banks_total = v.nb;    cfg_banks_used = v.used;  cfg_read_pct = v.pct;
    cfg_gap_min = v.gmin;      cfg_gap_max = v.gmax;     cfg_seed = v.seed;
  endtask

  task automatic wait_valid(output int lows);
    lows = 0;
    while (!req_valid && lows < 400) begin
      lows++;
      @(negedge clk);
    end
  endtask

  task automatic stop_run();
    run = 1'b0;
    req_ready = 1'b1;
    repeat (3) @(negedge clk);
    req_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk(!req_valid, "R12", "valid after stop", longint'(req_valid), 0);
  endtask

  task automatic run_vec(input vec_t v);
    int lows;
    longint row, bank, col, prow, pbank, pcol;
    longint nbeat = longint'(v.stride) / longint'(v.req);
    longint ncol  = longint'(v.page) / longint'(v.req);
    apply(v);
    @(negedge clk);
    run = 1'b1;
    if (v.err) begin
      repeat (3) @(negedge clk);
      chk(cfg_err == 1'b1, "R2", "err flag", longint'(cfg_err), 1);
      for (int i = 0; i < 6; i++) begin
        chk(!req_valid, "R2", "valid while rejected", longint'(req_valid), 0);
        @(negedge clk);
      end
      run = 1'b0;
      repeat (2) @(negedge clk);
      chk(!cfg_err, "R2", "err clears", longint'(cfg_err), 0);
      return;
    end
    @(negedge clk);
    wait_valid(lows);
    prow = 0; pbank = 0; pcol = 0;
    for (int k = 0; k < 12; k++) begin
      logic [31:0] a = req_addr;
      logic        w = req_write;
      chk(req_valid, "R10", "valid seen", longint'(req_valid), 1);
      chk(a >= v.base && a < v.limit && (a & (32'(v.req) - 1)) == 0,
          "R5", "addr window/align", longint'(a), longint'(v.base));
      chk(req_size == v.req, "R5", "size", longint'(req_size), longint'(v.req));
      decode(v, a, row, bank, col);
      chk(bank < longint'(v.used), "R7", "bank in subset", bank, longint'(v.used));
      if ((k % nbeat) == 0) begin
        chk(col + nbeat <= ncol, "R6", "run fits page", col + nbeat, ncol);
      end else begin
        chk(row == prow && bank == pbank, "R6", "same row/bank", row, prow);
        chk(col == pcol + 1, "R8", "column step", col, pcol + 1);
      end
      if (v.pct == 7'd0)   chk(w == 1'b1, "R9", "all writes", longint'(w), 1);
      if (v.pct == 7'd100) chk(w == 1'b0, "R9", "all reads", longint'(w), 0);
      prow = row; pbank = bank; pcol = col;
      if (k % 2 == 1) begin
        repeat (2) begin
          @(negedge clk);
          chk(req_valid && req_addr == a && req_write == w, "R4", "held under stall",
              longint'(req_addr), longint'(a));
        end
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      chk(!req_valid, "R10", "low after transfer", longint'(req_valid), 0);
      if (k < 11) begin
        wait_valid(lows);
        chk(lows >= int'(v.gmin) + 1 && lows <= int'(v.gmax) + 1, "R10", "gap length",
            longint'(lows), longint'(v.gmin) + 1);
      end
    end
    stop_run();
  endtask

  task automatic grab4(input vec_t v, output logic [31:0] a0, output logic [31:0] a3);
    int n = 0;
    int guard = 0;
    apply(v);
    req_ready = 1'b1;
    @(negedge clk);
    run = 1'b1;
    a0 = '0; a3 = '0;
    while (n < 4 && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (req_valid) begin
        if (n == 0) a0 = req_addr;
        if (n == 3) a3 = req_addr;
        n++;
      end
    end
    chk(n == 4, "R11", "stream produced", longint'(n), 4);
    stop_run();
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] x0, x3, y0, y3;
    vec_t v;
    req_ready = 1'b0;
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    // R1
    chk(!req_valid && !cfg_err, "R1", "in reset", longint'({req_valid, cfg_err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!req_valid && !cfg_err, "R1", "after reset", longint'({req_valid, cfg_err}), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R3: start latency
    apply(VECS[2]);
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    chk(!req_valid, "R3", "low after first edge", longint'(req_valid), 0);
    @(negedge clk);
    chk(req_valid, "R3", "high after second edge", longint'(req_valid), 1);

    // R12: run falls while the request is stalled
    x0 = req_addr;
    run = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(req_valid && req_addr == x0, "R12", "pending kept", longint'(req_addr), longint'(x0));
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    for (int i = 0; i < 10; i++) begin
      chk(!req_valid, "R12", "silent after stop", longint'(req_valid), 0);
      @(negedge clk);
    end

    // R11: repeatability and zero seed
    grab4(VECS[0], x0, x3);
    grab4(VECS[0], y0, y3);
    chk(x0 == y0 && x3 == y3, "R11", "same seed same stream", longint'(y3), longint'(x3));
    v = VECS[1];
    v.seed = 32'h0;
    grab4(v, y0, y3);
    chk(y0 >= v.base && y0 < v.limit, "R11", "zero seed runs", longint'(y0), longint'(v.base));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule